// File: doc/BRIEF.md
# Bit-Serial Clock and NVRAM Command Port

This block is the slave side of a three-wire serial link that software drives by toggling bits in a system control register. A frame begins when the enable bit is raised. Each falling edge of the serial clock, taken while enable is high, clocks in one bit. The first eight edges form a command byte and the next eight form a data byte, both most significant bit first. For read commands the block presents one result bit per data edge on `rd_bit`. Software reads that bit back from the same control register.

Behind the port sit a 32-byte battery-backed RAM, an 8-bit status register, a constant control register and a set of time-of-day registers. The time-of-day registers are formed from an external binary time bus and returned as two-digit BCD. The port's command decoder picks RAM read or write, time read, status or control read, or a status write. A status write can clear the power-fail flags and send a one-cycle strobe that clears the matching interrupt at the system level. The asynchronous reset is released through a two-stage synchronizer.

Top module: `rtc_serial_port`

## Requirements
- R1: `ctl_i[0]` is enable, `ctl_i[1]` is serial clock and `ctl_i[2]` is serial data. A bit is accepted only on a sampled high-to-low change of `ctl_i[1]` while `ctl_i[0]` is high. Clock edges seen while enable is low have no effect.
- R2: The first eight accepted edges of a frame shift in the command byte and the next eight shift in the data byte, both most significant bit first.
- R3: Commands 0x00 to 0x1F read RAM byte `cmd[4:0]`. On the k-th data edge (k = 0..7) `rd_bit` takes bit 7-k of that byte.
- R4: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return, in that order, seconds, minutes, hours, day of month, month and (year since 1900 minus 100), each as BCD with the tens digit in bits 7:4. Every other command from 0x20 to 0x2F returns 0x00.
- R5: Command 0x30 returns the status register and command 0x31 returns the control register (parameter `CTRL_INIT`).
- R6: On the sixteenth accepted edge, a command from 0x80 to 0x9F writes the data byte into RAM address `cmd - 0x80`.
- R7: On the sixteenth accepted edge, command 0xB1 with data bit 2 set clears status bits 4 and 3 and pulses `clr_irq` high for exactly one cycle. With data bit 2 clear it changes nothing.
- R8: Enable low aborts the frame. The phase count, command and data are cleared and `rd_bit` goes to 0 in the next cycle.
- R9: Falling edges after the sixteenth within one frame are ignored until enable is dropped. They make no further writes and do not change `rd_bit`.
- R10: `rd_bit` changes only on accepted data-phase edges or on an abort, and holds its value in between. Commands other than reads return 0 bits.
- R11: After reset the status register is 0x90 (parameter `STATUS_INIT`), RAM byte i holds `((i*37+11) mod 256) XOR 0x3C`, and `rd_bit` and `clr_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 3 | Control bits: 0 enable, 1 serial clock, 2 serial data |
| tod_sec | input | 6 | Binary seconds 0..59 |
| tod_min | input | 6 | Binary minutes 0..59 |
| tod_hour | input | 5 | Binary hours 0..23 |
| tod_mday | input | 5 | Binary day of month 1..31 |
| tod_mon | input | 4 | Binary month 1..12 |
| tod_year | input | 8 | Binary years since 1900, 100..199 |
| rd_bit | output | 1 | Returned serial data bit |
| clr_irq | output | 1 | One-cycle strobe that clears the power-fail interrupt |

## Verification
The bench builds the block with its default parameters: status reset value 0x90 and control value 0x00. At this size every RAM address can be read from its reset image, written with a distinct pattern and read back. All sixteen commands in the time range are swept under three time-of-day settings, including the boundary values 59, 23, 31, 12 and the years 100 and 199. Aborts in the middle of the command and data phases, clock activity with enable low, the edges after the sixteenth, and both outcomes of a status write are driven and checked through `rd_bit` and `clr_irq`.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

  localparam int unsigned RAM_BYTES = 32;
  localparam int unsigned RAM_AW    = $clog2(RAM_BYTES);
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned PHASE_W   = $clog2(FRAME_LEN) + 1;

  typedef enum logic [2:0] {
    K_NONE,
    K_RAM_RD,
    K_TIME_RD,
    K_STAT_RD,
    K_CTRL_RD,
    K_RAM_WR,
    K_STAT_WR
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [7:0] c);
    cmd_kind_e k;
    if (c[7:5] == 3'b000)      k = K_RAM_RD;
    else if (c[7:4] == 4'h2)   k = K_TIME_RD;
    else if (c == 8'h30)       k = K_STAT_RD;
    else if (c == 8'h31)       k = K_CTRL_RD;
    else if (c[7:5] == 3'b100) k = K_RAM_WR;
    else if (c == 8'hB1)       k = K_STAT_WR;
    else                       k = K_NONE;
    return k;
  endfunction

  function automatic logic [7:0] ram_default(input int unsigned i);
    logic [7:0] r;
    r = 8'((i * 37) + 11);
    return r ^ 8'h3C;
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v - (tens * 8'd10);
    return (tens << 4) | ones;
  endfunction

endpackage

// File: rtl/rtc_serial_frame.sv
module rtc_serial_frame
  import rtc_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sclk,
  input  logic               sdata,
  output logic [PHASE_W-1:0] phase,
  output logic [7:0]         cmd,
  output logic [7:0]         val_nxt,
  output logic               data_evt,
  output logic               commit
);

  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(FRAME_LEN - 1);
  localparam int unsigned        HALF_B  = $clog2(FRAME_LEN / 2);

  logic               sclk_q;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [7:0]         cmd_q, cmd_d;
  logic [6:0]         val_q, val_d;
  logic               take;
  logic               in_data;

  // accepted edge: falling serial clock, enable high, frame not yet complete
  assign take    = en & sclk_q & ~sclk & ~phase_q[PHASE_W-1];
  assign in_data = phase_q[HALF_B];

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    val_d   = val_q;
    if (!en) begin
      phase_d = '0;
      cmd_d   = '0;
      val_d   = '0;
    end else if (take) begin
      phase_d = phase_q + PHASE_W'(1);
      if (in_data) val_d = {val_q[5:0], sdata};
      else         cmd_d = {cmd_q[6:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
    end else begin
      sclk_q  <= sclk;
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      val_q   <= val_d;
    end
  end

  assign phase    = phase_q;
  assign cmd      = cmd_q;
  assign val_nxt  = {val_q, sdata};
  assign data_evt = take & in_data;
  assign commit   = take & (phase_q == LAST_PH);

endmodule

// File: rtl/rtc_serial_nvram.sv
module rtc_serial_nvram
  import rtc_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem_q [RAM_BYTES];

  for (genvar g = 0; g < RAM_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = we & (addr == RAM_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= ram_default(g);
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/rtc_serial_tod.sv
module rtc_serial_tod
  import rtc_serial_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [5:0] tod_sec,
  input  logic [5:0] tod_min,
  input  logic [4:0] tod_hour,
  input  logic [4:0] tod_mday,
  input  logic [3:0] tod_mon,
  input  logic [7:0] tod_year,
  output logic [7:0] bcd
);

  logic [7:0] yr_off;
  assign yr_off = tod_year - 8'd100;

  always_comb begin
    unique case (sel)
      4'h0:    bcd = to_bcd({2'b00, tod_sec});
      4'h1:    bcd = to_bcd({2'b00, tod_min});
      4'h2:    bcd = to_bcd({3'b000, tod_hour});
      4'h4:    bcd = to_bcd({3'b000, tod_mday});
      4'h5:    bcd = to_bcd({4'h0, tod_mon});
      4'h6:    bcd = to_bcd(yr_off);
      default: bcd = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_serial_pkg::*;
#(
  parameter logic [7:0] STATUS_INIT = 8'h90,
  parameter logic [7:0] CTRL_INIT   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctl_i,
  input  logic [5:0] tod_sec,
  input  logic [5:0] tod_min,
  input  logic [4:0] tod_hour,
  input  logic [4:0] tod_mday,
  input  logic [3:0] tod_mon,
  input  logic [7:0] tod_year,
  output logic       rd_bit,
  output logic       clr_irq
);

  localparam logic [7:0] PF_MASK = 8'h18;

  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic               en;
  logic [PHASE_W-1:0] phase;
  logic [7:0]         cmd, val_nxt;
  logic               data_evt, commit;
  cmd_kind_e          kind;

  assign en = ctl_i[0];

  rtc_serial_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (en),
    .sclk     (ctl_i[1]),
    .sdata    (ctl_i[2]),
    .phase    (phase),
    .cmd      (cmd),
    .val_nxt  (val_nxt),
    .data_evt (data_evt),
    .commit   (commit)
  );

  assign kind = decode_cmd(cmd);

  logic       ram_we;
  logic [7:0] ram_rd, tod_rd;

  assign ram_we = commit & (kind == K_RAM_WR);

  rtc_serial_nvram u_nvram (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (ram_we),
    .addr  (cmd[RAM_AW-1:0]),
    .wdata (val_nxt),
    .rdata (ram_rd)
  );

  rtc_serial_tod u_tod (
    .sel      (cmd[3:0]),
    .tod_sec  (tod_sec),
    .tod_min  (tod_min),
    .tod_hour (tod_hour),
    .tod_mday (tod_mday),
    .tod_mon  (tod_mon),
    .tod_year (tod_year),
    .bcd      (tod_rd)
  );

  logic [7:0] status_q, status_d;
  logic [7:0] src_byte;
  logic       sel_bit;
  logic       rd_q, rd_d;
  logic       clr_q, stat_clr;

  always_comb begin
    unique case (kind)
      K_RAM_RD:  src_byte = ram_rd;
      K_TIME_RD: src_byte = tod_rd;
      K_STAT_RD: src_byte = status_q;
      K_CTRL_RD: src_byte = CTRL_INIT;
      default:   src_byte = 8'h00;
    endcase
  end

  // data phase k (k = phase - 8) returns bit 7-k
  assign sel_bit  = src_byte[~phase[2:0]];
  assign stat_clr = commit & (kind == K_STAT_WR) & val_nxt[2];

  always_comb begin
    rd_d     = rd_q;
    status_d = status_q;
    if (!en)           rd_d = 1'b0;
    else if (data_evt) rd_d = sel_bit;
    if (stat_clr)      status_d = status_q & ~PF_MASK;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_q     <= 1'b0;
      clr_q    <= 1'b0;
      status_q <= STATUS_INIT;
    end else begin
      rd_q     <= rd_d;
      clr_q    <= stat_clr;
      status_q <= status_d;
    end
  end

  assign rd_bit  = rd_q;
  assign clr_irq = clr_q;

endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctl_i,
  input logic       rd_bit,
  input logic       clr_irq,
  input logic [4:0] phase,
  input logic [7:0] status
);

  logic sclk_prev;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= ctl_i[1];
  end
  assign fall = sclk_prev & ~ctl_i[1];

  // R10: output held unless an edge or an abort occurs
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[0] && !fall) |=> $stable(rd_bit));

  // R1: phase advances only on a falling serial clock with enable high
  p_phase_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[0] && !fall) |=> $stable(phase));

  // R8: abort clears phase and output
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i[0] |=> (phase == 5'd0 && !rd_bit));

  // R9: frame length bounded and saturating
  p_phase_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 5'd16);

  p_phase_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 5'd16 && ctl_i[0]) |=> phase == 5'd16);

  // R7: strobe is a single cycle and accompanies the flag clear
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |=> !clr_irq);

  p_clr_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |-> (status & 8'h18) == 8'h00);

  p_status_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> clr_irq);

endmodule

bind rtc_serial_port rtc_serial_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .ctl_i   (ctl_i),
  .rd_bit  (rd_bit),
  .clr_irq (clr_irq),
  .phase   (phase),
  .status  (status_q)
);

// File: tb/rtc_serial_port_bench.sv
module rtc_serial_port_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ctl;
  logic [5:0] tsec, tmin;
  logic [4:0] thour, tmday;
  logic [3:0] tmon;
  logic [7:0] tyear;
  logic       rd_bit, clr_irq;

  int n_chk = 0;
  int n_bad = 0;
  int n_clr = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rtc_serial_port u_rtc_serial_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_i    (ctl),
    .tod_sec  (tsec),
    .tod_min  (tmin),
    .tod_hour (thour),
    .tod_mday (tmday),
    .tod_mon  (tmon),
    .tod_year (tyear),
    .rd_bit   (rd_bit),
    .clr_irq  (clr_irq)
  );

  always @(negedge clk) if (clr_irq) n_clr++;

  function automatic logic [7:0] exp_ram(input int i);
    return 8'((i * 37 + 11) % 256) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] exp_bcd(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic d);
    @(negedge clk) begin ctl[1] = 1'b1; ctl[2] = d; end
    @(negedge clk) ctl[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] v, output logic [7:0] got);
    @(negedge clk) ctl[0] = 1'b1;
    for (int i = 7; i >= 0; i--) sbit(c[i]);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      sbit(v[i]);
      got = {got[6:0], rd_bit};
    end
  endtask

  task automatic idle();
    @(negedge clk) ctl = 3'b000;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] v, output logic [7:0] got);
    frame(c, v, got);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int         tv [3][6];
    ctl = 3'b000;
    tsec = 6'd0; tmin = 6'd0; thour = 5'd0; tmday = 5'd1; tmon = 4'd1; tyear = 8'd100;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state at the ports
    check("R11 rd_bit reset", {7'd0, rd_bit}, 8'h00);
    check("R11 clr_irq reset", {7'd0, clr_irq}, 8'h00);

    // R5 R11: status reset value, control value
    xfer(8'h30, 8'h00, r); check("R5 R11 status read", r, 8'h90);
    xfer(8'h31, 8'h00, r); check("R5 control read", r, 8'h00);

    // R3 R11: default RAM image, every address
    for (int i = 0; i < 32; i++) begin
      xfer(8'(i), 8'h00, r);
      check("R3 R11 default ram", r, exp_ram(i));
    end

    // R6 R2: write every address, then read back
    for (int i = 0; i < 32; i++) xfer(8'h80 + 8'(i), 8'(i * 7) ^ 8'hA5, r);
    for (int i = 0; i < 32; i++) begin
      xfer(8'(i), 8'h00, r);
      check("R6 R2 ram write readback", r, 8'(i * 7) ^ 8'hA5);
    end

    // R4: time sweep under three settings
    tv[0] = '{59, 7, 23, 31, 12, 199};
    tv[1] = '{0, 0, 0, 1, 1, 100};
    tv[2] = '{45, 30, 12, 15, 6, 124};
    for (int s = 0; s < 3; s++) begin
      tsec = 6'(tv[s][0]); tmin = 6'(tv[s][1]); thour = 5'(tv[s][2]);
      tmday = 5'(tv[s][3]); tmon = 4'(tv[s][4]); tyear = 8'(tv[s][5]);
      for (int c = 0; c < 16; c++) begin
        logic [7:0] e;
        case (c)
          0: e = exp_bcd(tv[s][0]);
          1: e = exp_bcd(tv[s][1]);
          2: e = exp_bcd(tv[s][2]);
          4: e = exp_bcd(tv[s][3]);
          5: e = exp_bcd(tv[s][4]);
          6: e = exp_bcd(tv[s][5] - 100);
          default: e = 8'h00;
        endcase
        xfer(8'h20 + 8'(c), 8'h00, r);
        check("R4 time bcd", r, e);
      end
    end

    // R10: non-read commands return zero bits
    xfer(8'h40, 8'hFF, r); check("R10 non-read returns zero", r, 8'h00);
    xfer(8'hB0, 8'hFF, r); check("R10 non-read returns zero", r, 8'h00);

    // R1: clock activity with enable low has no effect
    @(negedge clk) ctl = 3'b000;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) ctl = 3'b110;
      @(negedge clk) ctl = 3'b100;
    end
    check("R1 disabled edges ignored", {7'd0, rd_bit}, 8'h00);
    xfer(8'h03, 8'h00, r); check("R1 ram unchanged after disabled edges", r, 8'(3 * 7) ^ 8'hA5);

    // R8: abort during command phase, next frame aligns from zero
    @(negedge clk) ctl[0] = 1'b1;
    for (int i = 0; i < 4; i++) sbit(1'b1);
    idle();
    xfer(8'h30, 8'h00, r); check("R8 frame after command abort", r, 8'h90);

    // R8: abort during data phase clears returned bit
    @(negedge clk) ctl[0] = 1'b1;
    for (int i = 7; i >= 0; i--) sbit(((8'h30 >> i) & 8'h01) != 0);
    sbit(1'b0);
    check("R8 first status bit before abort", {7'd0, rd_bit}, 8'h01);
    @(negedge clk) ctl = 3'b000;
    @(negedge clk);
    check("R8 rd_bit cleared by abort", {7'd0, rd_bit}, 8'h00);

    // R7: status write without bit 2 changes nothing
    xfer(8'hB1, 8'hFB, r);
    repeat (2) @(negedge clk);
    check("R7 no strobe without bit 2", 8'(n_clr), 8'h00);
    xfer(8'h30, 8'h00, r); check("R7 status kept without bit 2", r, 8'h90);

    // R7: status write with bit 2 clears flags, single strobe
    xfer(8'hB1, 8'h04, r);
    repeat (2) @(negedge clk);
    check("R7 single clear strobe", 8'(n_clr), 8'h01);
    xfer(8'h30, 8'h00, r); check("R7 status flags cleared", r, 8'h80);

    // R9: edges after the sixteenth ignored (write)
    frame(8'h85, 8'h3D, r);
    for (int i = 0; i < 8; i++) sbit(1'b1);
    idle();
    xfer(8'h05, 8'h00, r); check("R9 extra edges no second write", r, 8'h3D);

    // R9 R10: edges after the sixteenth leave rd_bit held
    frame(8'h05, 8'h00, r);
    check("R9 read before extra edges", r, 8'h3D);
    for (int i = 0; i < 8; i++) begin
      sbit(1'b0);
      check("R9 R10 rd_bit held after frame end", {7'd0, rd_bit}, 8'h01);
    end
    idle();

    finish_run();
  end

endmodule